// File: doc/BRIEF.md
# Daisy-Chainable Serial Control Port

This block is the serial slave port of a triple half-bridge driver. A host frames each transfer by pulling the active-low select low. While select is low, the port moves a 16-bit command word in on `sdi` and a 16-bit status word out on `sdo`, least significant bit first. The serial clock idles high. The port samples `sdi` on each falling edge of `sclk` and advances `sdo` on each rising edge. The status word is latched into the output shifter when select falls, so its bit 0 (the temperature prewarning flag) can be read before any clock edge. The received word becomes the active command only when select rises after exactly 16 falling clock edges. Any other frame is thrown away.

Command layout, which downstream switch logic decodes:
- Bit 0 requests a status clear.
- Bits 1 to 6 switch the low and high side of each of the three half-bridges, in the order low 1, high 1, low 2, high 2, low 3, high 3.
- Bit 13 enables overcurrent shutdown.
- A word with bits 15 and 14 both set is a reserved test pattern and is never applied.

Status layout, which the fault logic assembles on `stat_word`:
- Bit 0 is the prewarning flag.
- Bits 1 to 6 carry the switch states, in the same order as the command.
- Bit 13 flags a short.
- Bit 14 flags an open load.
- Bit 15 flags a supply failure.

Bits shifted in also leave on `sdo` sixteen clocks later, so several ports can be daisy-chained. The port runs on a fast system clock and oversamples the serial pins through two-flop synchronizers and edge detectors. The system clock must be at least eight times the serial clock.

Top module: `serial_ctrl_port`

## Requirements
- R1: During and right after reset, `cmd_word` equals 0x2000: bit 13 (overcurrent shutdown enable) is high, and bit 0 and the switch controls in bits 1 to 6 are low. `sdo_oe` is low.
- R2: A frame with exactly 16 falling `sclk` edges, carrying `sdi` least significant bit first, is loaded into `cmd_word` after `sel_n` rises. `cmd_word` does not change while `sel_n` stays low.
- R3: A frame with any other number of falling `sclk` edges (for example 15, 17 or 32) leaves `cmd_word` unchanged.
- R4: A 16-bit word with bits 15 and 14 both 1 is discarded. A word with only one of those two bits set is applied normally.
- R5: `sdo_oe` is low while `sel_n` is high and high during a frame, so several ports can share one return line.
- R6: Bit 0 of `stat_word` is on `sdo` as soon as the frame opens, before any `sclk` edge. After the k-th rising `sclk` edge, `sdo` carries status bit k. It holds that value until the next rising edge.
- R7: A frame closed with no `sclk` edges at all (a prewarning-only read) leaves `cmd_word` unchanged.
- R8: The `sdi` bit sampled at the k-th falling edge of a frame (counting from 0) appears on `sdo` after rising edge k+16. For example, with 32 clocks the first word sent comes back out as the second word read.
- R9: `stat_word` is captured when the frame opens. Changing it during the frame does not alter the bits shifted out on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial command data, LSB first |
| stat_word | input | WORD_W | Status word from the fault logic |
| sdo | output | 1 | Serial status data, LSB first |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| cmd_word | output | WORD_W | Currently applied command word |

## Verification
The bench targets four edge cases, each with the failure it would catch:
- **Frames one bit short or long, and a 32-bit chained transfer.** A port that commits on every rising select, or only checks for "at least 16", would load garbage into the switch controls.
- **Reserved test pattern, next to words with a single top bit set.** An over-eager guard would reject legal commands, and a missing one would let a test mode through.
- **Select toggled with no clock, and a status word that changes mid-frame.** A port that loads status late, or keeps following the status input, would show the wrong prewarning bit or a torn word.
- **The sixteen-clock delay from `sdi` to `sdo`.** An off-by-one in the shifter would break every device further down the chain.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;

   // Per-line edge report from the edge detector
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

   // Reserved test patterns have both top command bits set
   function automatic logic is_test_pattern(input logic [1:0] top2);
      return top2[1] & top2[0];
   endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int          N       = 1,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sync_chain: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= {STAGES{RST_VAL[i]}};
         else        st <= {st[STAGES-2:0], d[i]};
      end
      assign q[i] = st[STAGES-1];
   end

endmodule

// File: rtl/edge_det.sv
module edge_det
   import serial_ctrl_pkg::*;
#(
   parameter int           N       = 1,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output edge_t        ev [N]
);

   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_ev
      assign ev[i].rise = lvl[i] & ~prev[i];
      assign ev[i].fall = ~lvl[i] & prev[i];
   end

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stb,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              full,
   output logic              last
);

   localparam int CW = $clog2(WORD_W + 2);
   localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
   localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_W + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         word <= '0;
         last <= 1'b0;
      end else if (start) begin
         cnt <= '0;
      end else if (stb) begin
         word <= {din, word[WORD_W-1:1]};
         last <= din;
         if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CNT_FULL);

endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   input  logic              fill,
   output logic              bit_out
);

   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= load_word;
      else if (shift) sr <= {fill, sr[WORD_W-1:1]};
   end

   assign bit_out = sr[0];

endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
   import serial_ctrl_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int OVC_BIT     = 13,
   parameter bit GUARD_TEST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic [WORD_W-1:0] stat_word,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [WORD_W-1:0] cmd_word
);

   localparam logic [WORD_W-1:0] CMD_RST = WORD_W'(1) << OVC_BIT;

   if (WORD_W < 4) begin : g_bad_width
      $error("serial_ctrl_port: WORD_W must be at least 4");
   end
   if (OVC_BIT >= WORD_W - 2) begin : g_bad_ovc
      $error("serial_ctrl_port: OVC_BIT must sit below the two test-pattern bits");
   end

   // Synchronized pin levels: [2]=select, [1]=serial clock, [0]=data in
   logic [2:0] pin_s;
   sync_chain #(
      .N       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n, sclk, sdi}),
      .q     (pin_s)
   );

   // Edges of select and serial clock, taken from the same synchronized levels
   edge_t ev [2];
   edge_det #(
      .N       (2),
      .RST_VAL (2'b11)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_s[2:1]),
      .ev    (ev)
   );

   logic sel_open, sel_close, ck_fall, ck_rise;
   assign sel_open  = ev[1].fall;
   assign sel_close = ev[1].rise;
   assign ck_fall   = ev[0].fall;
   assign ck_rise   = ev[0].rise;

   logic active;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         active <= 1'b0;
      else if (sel_open)  active <= 1'b1;
      else if (sel_close) active <= 1'b0;
   end

   logic [WORD_W-1:0] rx_word;
   logic              rx_full, rx_last;
   frame_rx #(.WORD_W(WORD_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sel_open),
      .stb   (active & ck_fall),
      .din   (pin_s[0]),
      .word  (rx_word),
      .full  (rx_full),
      .last  (rx_last)
   );

   frame_tx #(.WORD_W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sel_open),
      .load_word (stat_word),
      .shift     (active & ck_rise),
      .fill      (rx_last),
      .bit_out   (sdo)
   );

   // Pattern guard variant chosen by parameter
   logic pat_ok;
   if (GUARD_TEST) begin : g_guard
      assign pat_ok = ~is_test_pattern(rx_word[WORD_W-1 -: 2]);
   end else begin : g_noguard
      assign pat_ok = 1'b1;
   end

   logic commit;
   assign commit = active & sel_close & rx_full & pat_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_word <= CMD_RST;
      else if (commit) cmd_word <= rx_word;
   end

   assign sdo_oe = active;

endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk #(
   parameter int WORD_W  = 16,
   parameter int OVC_BIT = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic [WORD_W-1:0] stat_word,
   input logic              sdo,
   input logic              sdo_oe,
   input logic [WORD_W-1:0] cmd_word
);

   localparam logic [WORD_W-1:0] CMD_RST = WORD_W'(1) << OVC_BIT;

   logic [2:0] cyc;
   logic       was_rst = 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 1'b1;
   end

   // R1
   always_ff @(posedge clk) begin
      if (was_rst) begin
         reset_val_chk: assert (cmd_word == CMD_RST && !sdo_oe)
            else $error("reset state wrong");
      end
      was_rst <= !rst_n;
   end

   // R5
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd4 && sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3) && $past(sel_n, 4))
      |-> !sdo_oe);

   // R2
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd5 && !sel_n && !$past(sel_n) && !$past(sel_n, 2) && !$past(sel_n, 3) && !$past(sel_n, 4))
      |-> $stable(cmd_word));

   // R4
   no_test_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_word[WORD_W-1] && cmd_word[WORD_W-2]));

   // R6
   first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd1 && $rose(sdo_oe)) |-> (sdo == $past(stat_word[0])));

endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(
   .WORD_W  (WORD_W),
   .OVC_BIT (OVC_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_n     (sel_n),
   .stat_word (stat_word),
   .sdo       (sdo),
   .sdo_oe    (sdo_oe),
   .cmd_word  (cmd_word)
);

// File: tb/sim_serial_ctrl_port.sv
module sim_serial_ctrl_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdi = 1'b0;
   logic [15:0] stat_word = '0;
   logic        sdo, sdo_oe;
   logic [15:0] cmd_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   serial_ctrl_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .stat_word (stat_word),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .cmd_word  (cmd_word)
   );

   // {command sent, status offered, falling-edge count}
   localparam logic [37:0] VEC [0:7] = '{
      {16'h007E, 16'hA5C3, 6'd16},
      {16'h2015, 16'h0001, 6'd16},
      {16'h1234, 16'hFFFF, 6'd15},
      {16'h0F0F, 16'h8000, 6'd17},
      {16'hC000, 16'h1234, 6'd16},
      {16'h8002, 16'h4321, 6'd16},
      {16'h4002, 16'h0000, 6'd16},
      {16'hFFFF, 16'h5A5A, 6'd16}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs one frame; counts sdo slot mismatches against the rule of R6/R8/R9
   task automatic frame(input logic [15:0] w, input logic [15:0] st, input int n,
                        input bit chg, output int bad, output logic oe_in);
      logic e;
      bad = 0;
      stat_word = st;
      wait_n(2);
      sel_n = 1'b0;
      wait_n(8);
      oe_in = sdo_oe;
      for (int i = 0; i < n; i++) begin
         e = (i < 16) ? st[i] : w[(i - 16) % 16];
         if (sdo !== e) bad++;
         if (chg && i == 3) stat_word = ~st;
         sdi = w[i % 16];
         wait_n(2);
         sclk = 1'b0;
         wait_n(8);
         if (sdo !== e) bad++;
         sclk = 1'b1;
         wait_n(8);
      end
      wait_n(4);
      sel_n = 1'b1;
      wait_n(10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp_cmd;
      int          bad;
      logic        oe_in;

      wait_n(3);
      // R1: reset state
      chk(cmd_word == 16'h2000, "R1 reset command", cmd_word, 16'h2000);
      chk(sdo_oe == 1'b0, "R1 reset oe", sdo_oe, 0);
      rst_n = 1'b1;
      wait_n(4);
      chk(cmd_word == 16'h2000, "R1 command after reset", cmd_word, 16'h2000);
      exp_cmd = 16'h2000;

      // Table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < 8; v++) begin
         logic [15:0] w, st;
         int n;
         w  = VEC[v][37:22];
         st = VEC[v][21:6];
         n  = int'(VEC[v][5:0]);
         frame(w, st, n, 1'b0, bad, oe_in);
         if (n == 16 && !(w[15] && w[14])) exp_cmd = w;
         chk(oe_in == 1'b1, "R5 oe during frame", oe_in, 1);
         chk(sdo_oe == 1'b0, "R5 oe after frame", sdo_oe, 0);
         chk(bad == 0, "R6 status shifted out", bad, 0);
         chk(cmd_word == exp_cmd, (n != 16) ? "R3 frame length" :
             ((w[15] && w[14]) ? "R4 test pattern" : "R2 commit"), cmd_word, exp_cmd);
      end

      // R7: prewarning-only read, no clocks
      stat_word = 16'h0001;
      wait_n(2);
      sel_n = 1'b0;
      wait_n(8);
      chk(sdo == 1'b1, "R6 first bit with no clock", sdo, 1);
      chk(sdo_oe == 1'b1, "R5 oe on partial read", sdo_oe, 1);
      sel_n = 1'b1;
      wait_n(10);
      chk(cmd_word == exp_cmd, "R7 partial read keeps command", cmd_word, exp_cmd);

      // R8: 32-clock chained transfer, second word read back is the first sent
      frame(16'h3C96, 16'h0F0F, 32, 1'b0, bad, oe_in);
      chk(bad == 0, "R8 daisy pass-through", bad, 0);
      chk(cmd_word == exp_cmd, "R3 32-bit frame discarded", cmd_word, exp_cmd);

      // R9: status changes mid-frame, shifted bits stay the captured word
      frame(16'h0054, 16'h6B2D, 16, 1'b1, bad, oe_in);
      chk(bad == 0, "R9 status captured at open", bad, 0);
      chk(cmd_word == 16'h0054, "R2 commit after R9 frame", cmd_word, 16'h0054);

      // R4: bit 14 alone is accepted
      frame(16'h4000, 16'h0000, 16, 1'b0, bad, oe_in);
      chk(cmd_word == 16'h4000, "R4 single top bit commits", cmd_word, 16'h4000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule